// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block hands out packet numbers for a packet buffer RAM split into 256-byte pages. A host issues 16-bit command words that ask for a packet of a given page count, give a packet back, push a packet number onto the transmit queue, pop the receive queue, or clear state. Every allocation request leaves its answer in a byte-wide result register. The answer is either the granted packet number or a failure flag.

A request that cannot be met stays pending. It is granted by itself once enough pages and a free packet number become available, and a one-cycle allocation-done pulse marks the grant. Releasing a packet takes two cycles, and a busy flag covers that window. The receive path pushes packet numbers through its own port. The transmit side pops the transmit queue head through a one-bit port. Two status words report the state to the host: one gives both queue heads with their empty flags, the other gives the free and total page counts.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset, alloc_result_o reads 0x80, busy_o and alloc_done_o are 0, queue_status_o reads 0x8080, and mem_info_o reads {NUM_PAGES, NUM_PAGES}.
- R2: The operation code is cmd_i[7:5]: 0 none, 1 allocate, 2 reset allocator, 3 drop RX head, 4 drop and free RX head, 5 free pkt_sel_i, 6 push pkt_sel_i to TX, 7 clear TX queue. An allocate asks for cmd_i[SIZE_W-1:0]+1 pages. The cycle after the write, alloc_result_o reads 0x80. If the request fits, then one cycle later alloc_result_o reads {0, packet number}, alloc_done_o is high for exactly one cycle, and the free count drops by the size. Code 0 changes nothing.
- R3: A grant always takes the lowest-numbered packet number that is not owned.
- R4: If there are too few free pages or no free packet number, alloc_result_o stays 0x80 and alloc_done_o stays low. The request is granted, with a single pulse, once a release makes it fit.
- R5: Code 5 with pkt_sel_i < NUM_PKTS sets busy_o for exactly one cycle. When busy_o falls, the packet's pages have returned to the free count. Freeing a packet that is not owned leaves the count unchanged.
- R6: A command written while busy_o is high is ignored.
- R7: Code 6 appends pkt_sel_i to the TX queue. queue_status_o[6:0] shows the head and bit 7 is set when the queue is empty (the head field then reads 0). A tx_pop_i pulse removes the head.
- R8: An rx_push_i pulse appends rx_pkt_i to the RX queue. queue_status_o[14:8] shows the head and bit 15 flags empty. Code 3 removes the head and leaves the free count alone. Code 4 removes the head and frees it as code 5 would.
- R9: Code 7 empties the TX queue and leaves the RX queue and the ownership alone.
- R10: Code 2 releases every packet, empties both queues, cancels a pending request and sets alloc_result_o to 0x80.
- R11: mem_info_o[15:8] is the free page count and mem_info_o[7:0] is NUM_PAGES.
- R12: A push into a queue that already holds NUM_PKTS entries is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 16 | Command word |
| pkt_sel_i | input | 7 | Packet number used by free and TX push |
| rx_push_i | input | 1 | Receive-side enqueue strobe |
| rx_pkt_i | input | 7 | Packet number to enqueue on RX |
| tx_pop_i | input | 1 | Removes the TX queue head |
| busy_o | output | 1 | Release in progress |
| alloc_result_o | output | 8 | Bit 7 failed/pending, low bits packet number |
| alloc_done_o | output | 1 | One-cycle pulse on a grant |
| queue_status_o | output | 16 | RX empty, RX head, TX empty, TX head |
| mem_info_o | output | 16 | Free pages (high byte), total pages (low byte) |

## Verification
The assertions assume the host never writes an allocate in the same cycle that a pending request could be granted. They also assume it never writes while busy_o is high, except for the one write made on purpose to show that it is ignored. The stimulus keeps to these rules: after each write it waits at least one idle cycle, and before each new command it reads busy_o and the allocation pulse. A page-accounting invariant covers every sequence: the free count plus the pages held by owned packets always equals the total.

// File: rtl/pkt_page_alloc_pkg.sv
package pkt_page_alloc_pkg;
  localparam int PKT_FIELD_W = 7;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_ALLOC    = 3'd1,
    OP_RESET    = 3'd2,
    OP_RX_DROP  = 3'd3,
    OP_RX_FREE  = 3'd4,
    OP_FREE     = 3'd5,
    OP_TX_PUSH  = 3'd6,
    OP_TX_CLEAR = 3'd7
  } op_e;
endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = empty_o ? '0 : mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      if (push_ok && !pop_ok) cnt_q <= cnt_q + CW'(1);
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  assert_count_bound_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_full_drop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clear_i) |=> full_o);
endmodule

// File: rtl/page_ledger.sv
module page_ledger #(
  parameter int NUM_PAGES = 32,
  parameter int NUM_PKTS  = 8,
  parameter int SIZE_W    = 3,
  localparam int PKT_IDX_W = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1,
  localparam int CNT_W     = $clog2(NUM_PAGES + 1),
  localparam int REQ_W     = SIZE_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 grant_i,
  input  logic [REQ_W-1:0]     req_pages_i,
  input  logic                 release_i,
  input  logic [PKT_IDX_W-1:0] release_pkt_i,
  output logic [CNT_W-1:0]     free_pages_o,
  output logic                 fit_o,
  output logic [PKT_IDX_W-1:0] grant_pkt_o
);
  logic [NUM_PKTS-1:0] owned_q;
  logic [REQ_W-1:0]    pages_q [NUM_PKTS];
  logic [CNT_W-1:0]    free_q;
  logic                idle_found;
  logic [15:0]         used_sum;

  // lowest free packet number wins
  always_comb begin
    idle_found  = 1'b0;
    grant_pkt_o = '0;
    for (int i = NUM_PKTS - 1; i >= 0; i--) begin
      if (!owned_q[i]) begin
        idle_found  = 1'b1;
        grant_pkt_o = PKT_IDX_W'(i);
      end
    end
  end

  assign fit_o        = idle_found && (free_q >= CNT_W'(req_pages_i));
  assign free_pages_o = free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owned_q <= '0;
      free_q  <= CNT_W'(NUM_PAGES);
      for (int i = 0; i < NUM_PKTS; i++) pages_q[i] <= '0;
    end else if (clear_i) begin
      owned_q <= '0;
      free_q  <= CNT_W'(NUM_PAGES);
      for (int i = 0; i < NUM_PKTS; i++) pages_q[i] <= '0;
    end else if (grant_i) begin
      owned_q[grant_pkt_o] <= 1'b1;
      pages_q[grant_pkt_o] <= req_pages_i;
      free_q               <= free_q - CNT_W'(req_pages_i);
    end else if (release_i && owned_q[release_pkt_i]) begin
      owned_q[release_pkt_i] <= 1'b0;
      free_q                 <= free_q + CNT_W'(pages_q[release_pkt_i]);
    end
  end

  always_comb begin
    used_sum = '0;
    for (int i = 0; i < NUM_PKTS; i++)
      if (owned_q[i]) used_sum = used_sum + 16'(pages_q[i]);
  end

  assert_page_balance_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (16'(free_q) + used_sum) == 16'(NUM_PAGES));
  assert_grant_fits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> fit_o);
  assert_free_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_q <= CNT_W'(NUM_PAGES));
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pkt_page_alloc_pkg::*;
#(
  parameter int NUM_PAGES = 32,
  parameter int NUM_PKTS  = 8,
  parameter int SIZE_W    = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [15:0] cmd_i,
  input  logic [6:0]  pkt_sel_i,
  input  logic        rx_push_i,
  input  logic [6:0]  rx_pkt_i,
  input  logic        tx_pop_i,
  output logic        busy_o,
  output logic [7:0]  alloc_result_o,
  output logic        alloc_done_o,
  output logic [15:0] queue_status_o,
  output logic [15:0] mem_info_o
);
  localparam int PKT_IDX_W = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1;
  localparam int CNT_W     = $clog2(NUM_PAGES + 1);
  localparam int REQ_W     = SIZE_W + 1;

  op_e                  op;
  logic                 accept, act;
  logic                 rel_q;
  logic [PKT_IDX_W-1:0] rel_pkt_q;
  logic                 pend_q;
  logic [REQ_W-1:0]     pend_pages_q;
  logic [7:0]           result_q;
  logic                 done_q;
  logic                 grant, fit, do_reset;
  logic [PKT_IDX_W-1:0] grant_pkt;
  logic [CNT_W-1:0]     free_pages;
  logic [PKT_FIELD_W-1:0] rx_head, tx_head;
  logic                 rx_empty, tx_empty, rx_full, tx_full;
  logic                 rx_pop, sel_ok, rx_ok;
  logic                 unused_bits;

  assign unused_bits = ^{cmd_i[15:8], cmd_i[4:0], rx_full, tx_full};

  assign op       = op_e'(cmd_i[7:5]);
  assign accept   = cmd_we_i && !rel_q;
  assign act      = accept && (op != OP_NOP);
  assign do_reset = accept && (op == OP_RESET);
  assign grant    = pend_q && fit && !rel_q && !act;
  assign sel_ok   = (pkt_sel_i < 7'(NUM_PKTS));
  assign rx_ok    = (rx_head < 7'(NUM_PKTS));
  assign rx_pop   = accept && !rx_empty && (op == OP_RX_DROP || op == OP_RX_FREE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q        <= 1'b0;
      rel_pkt_q    <= '0;
      pend_q       <= 1'b0;
      pend_pages_q <= '0;
      result_q     <= 8'h80;
      done_q       <= 1'b0;
    end else begin
      done_q <= grant;
      rel_q  <= 1'b0;
      if (grant) begin
        pend_q   <= 1'b0;
        result_q <= {1'b0, 7'(grant_pkt)};
      end
      if (accept) begin
        unique case (op)
          OP_ALLOC: begin
            pend_q       <= 1'b1;
            pend_pages_q <= REQ_W'(cmd_i[SIZE_W-1:0]) + REQ_W'(1);
            result_q     <= 8'h80;
          end
          OP_RESET: begin
            pend_q   <= 1'b0;
            result_q <= 8'h80;
          end
          OP_FREE: if (sel_ok) begin
            rel_q     <= 1'b1;
            rel_pkt_q <= PKT_IDX_W'(pkt_sel_i);
          end
          OP_RX_FREE: if (!rx_empty && rx_ok) begin
            rel_q     <= 1'b1;
            rel_pkt_q <= PKT_IDX_W'(rx_head);
          end
          default: ;
        endcase
      end
    end
  end

  page_ledger #(
    .NUM_PAGES (NUM_PAGES),
    .NUM_PKTS  (NUM_PKTS),
    .SIZE_W    (SIZE_W)
  ) u_ledger (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (do_reset),
    .grant_i       (grant),
    .req_pages_i   (pend_pages_q),
    .release_i     (rel_q),
    .release_pkt_i (rel_pkt_q),
    .free_pages_o  (free_pages),
    .fit_o         (fit),
    .grant_pkt_o   (grant_pkt)
  );

  pkt_fifo #(.DEPTH(NUM_PKTS), .W(PKT_FIELD_W)) u_rx_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (do_reset),
    .push_i  (rx_push_i),
    .data_i  (rx_pkt_i),
    .pop_i   (rx_pop),
    .head_o  (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  pkt_fifo #(.DEPTH(NUM_PKTS), .W(PKT_FIELD_W)) u_tx_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (do_reset || (accept && op == OP_TX_CLEAR)),
    .push_i  (accept && op == OP_TX_PUSH),
    .data_i  (pkt_sel_i),
    .pop_i   (tx_pop_i),
    .head_o  (tx_head),
    .empty_o (tx_empty),
    .full_o  (tx_full)
  );

  assign busy_o         = rel_q;
  assign alloc_result_o = result_q;
  assign alloc_done_o   = done_q;
  assign queue_status_o = {rx_empty, rx_head, tx_empty, tx_head};
  assign mem_info_o     = {8'(free_pages), 8'(NUM_PAGES)};

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_done_o |=> !alloc_done_o);
  assert_done_result_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_done_o |-> !alloc_result_o[7]);
  assert_busy_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);
  assert_busy_ignore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_we_i && cmd_i[7:5] == 3'd1) |=> $stable(alloc_result_o));
endmodule

// File: tb/pkt_page_alloc_tb.sv
module pkt_page_alloc_tb;
  localparam int NP = 32;
  localparam int NK = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [15:0] cmd = '0;
  logic [6:0]  pkt_sel = '0;
  logic        rx_push = 1'b0;
  logic [6:0]  rx_pkt = '0;
  logic        tx_pop = 1'b0;
  logic        busy, done;
  logic [7:0]  result;
  logic [15:0] qstat, minfo;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  bit m_owned [NK];
  int m_pages [NK];
  int m_free = NP;

  always #2 clk = ~clk;

  pkt_page_alloc #(.NUM_PAGES(NP), .NUM_PKTS(NK), .SIZE_W(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_i(cmd),
    .pkt_sel_i(pkt_sel), .rx_push_i(rx_push), .rx_pkt_i(rx_pkt),
    .tx_pop_i(tx_pop), .busy_o(busy), .alloc_result_o(result),
    .alloc_done_o(done), .queue_status_o(qstat), .mem_info_o(minfo)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] code, input logic [4:0] low, input logic [6:0] sel);
    @(negedge clk);
    cmd_we = 1'b1; cmd = {8'h00, code, low}; pkt_sel = sel;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  function automatic logic [15:0] exp_minfo();
    return {8'(m_free), 8'(NP)};
  endfunction

  function automatic int lowest_idle();
    for (int i = 0; i < NK; i++) if (!m_owned[i]) return i;
    return -1;
  endfunction

  // allocation expected to be granted
  task automatic alloc_ok(input int sz, input string req);
    int p;
    p = lowest_idle();
    issue(3'd1, 5'(sz), 7'd0);
    check({req, " pending byte"}, 16'(result), 16'h80);
    step();
    check({req, " done"}, 16'(done), 16'd1);
    check({req, " pkt"}, 16'(result), 16'(p));
    m_owned[p] = 1; m_pages[p] = sz + 1; m_free -= sz + 1;
    check({req, " R11 free"}, minfo, exp_minfo());
    step();
    check({req, " done pulse"}, 16'(done), 16'd0);
  endtask

  task automatic free_pkt(input int p, input string req);
    issue(3'd5, 5'd0, 7'(p));
    check({req, " busy"}, 16'(busy), 16'd1);
    step();
    check({req, " busy low"}, 16'(busy), 16'd0);
    if (m_owned[p]) begin m_owned[p] = 0; m_free += m_pages[p]; end
    check({req, " free count"}, minfo, exp_minfo());
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic push_rx(input logic [6:0] v);
    @(negedge clk); rx_push = 1'b1; rx_pkt = v;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < NK; i++) begin m_owned[i] = 0; m_pages[i] = 0; end
    m_free = NP;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] keep;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1
    check("R1 result", 16'(result), 16'h80);
    check("R1 busy", 16'(busy), 16'd0);
    check("R1 done", 16'(done), 16'd0);
    check("R1 queues", qstat, 16'h8080);
    check("R1 meminfo", minfo, {8'(NP), 8'(NP)});

    // R2 / R11: sweep every size
    for (int s = 0; s < 8; s++) begin
      alloc_ok(s, "R2 sweep");
      free_pkt(0, "R5 sweep");
    end

    // R2: code 0 has no effect
    issue(3'd0, 5'd3, 7'd0);
    step();
    check("R2 nop done", 16'(done), 16'd0);
    check("R2 nop meminfo", minfo, exp_minfo());

    // R4: fill pages, then wait for release
    for (int i = 0; i < 4; i++) alloc_ok(7, "R2 fill");
    issue(3'd1, 5'd0, 7'd0);
    repeat (3) begin
      step();
      check("R4 still pending", 16'(result), 16'h80);
      check("R4 no pulse", 16'(done), 16'd0);
    end
    issue(3'd5, 5'd0, 7'd1);
    check("R5 busy", 16'(busy), 16'd1);
    step();
    m_owned[1] = 0; m_free += 8;
    check("R5 released", minfo, exp_minfo());
    check("R4 not yet", 16'(done), 16'd0);
    step();
    m_owned[1] = 1; m_pages[1] = 1; m_free -= 1;
    check("R4 late grant", 16'(done), 16'd1);
    check("R4 late pkt", 16'(result), 16'd1);
    check("R4 late free", minfo, exp_minfo());
    step();
    check("R4 single pulse", 16'(done), 16'd0);

    // R3: lowest free number
    free_pkt(2, "R5 mid");
    alloc_ok(0, "R3 lowest");
    check("R3 took 2", 16'(result), 16'd2);

    // R5: unowned packet
    free_pkt(6, "R5 unowned");

    // R6: command during busy ignored
    keep = result;
    @(negedge clk); cmd_we = 1'b1; cmd = {8'h00, 3'd5, 5'd0}; pkt_sel = 7'd3;
    @(negedge clk); cmd = {8'h00, 3'd1, 5'd0};
    check("R6 busy seen", 16'(busy), 16'd1);
    @(negedge clk); cmd_we = 1'b0;
    m_owned[3] = 0; m_free += m_pages[3];
    check("R6 result kept", 16'(result), 16'(keep));
    check("R6 free", minfo, exp_minfo());
    repeat (2) begin
      step();
      check("R6 no grant", 16'(done), 16'd0);
    end

    // R10: out of packet numbers, then reset command
    issue(3'd2, 5'd0, 7'd0);
    model_reset();
    for (int i = 0; i < NK; i++) alloc_ok(0, "R2 numbers");
    issue(3'd1, 5'd0, 7'd0);
    step();
    check("R4 no number", 16'(result), 16'h80);
    check("R4 no number done", 16'(done), 16'd0);
    push_rx(7'd4);
    issue(3'd6, 5'd0, 7'd9);
    issue(3'd2, 5'd0, 7'd0);
    model_reset();
    check("R10 meminfo", minfo, exp_minfo());
    check("R10 result", 16'(result), 16'h80);
    check("R10 queues", qstat, 16'h8080);
    repeat (2) begin
      step();
      check("R10 pending cancelled", 16'(done), 16'd0);
    end

    // R7: TX queue
    issue(3'd6, 5'd0, 7'd3);
    check("R7 head", qstat, 16'h8003);
    issue(3'd6, 5'd0, 7'd5);
    check("R7 head kept", qstat, 16'h8003);
    pop_tx();
    check("R7 pop", qstat, 16'h8005);
    pop_tx();
    check("R7 empty", qstat, 16'h8080);

    // R12: overfill TX queue
    for (int i = 0; i <= NK; i++) issue(3'd6, 5'd0, 7'(10 + i));
    check("R12 head", qstat, 16'h800A);
    for (int i = 0; i < NK - 1; i++) pop_tx();
    check("R12 last kept", qstat, 16'(16'h8000 + 10 + NK - 1));
    pop_tx();
    check("R12 extra dropped", qstat, 16'h8080);

    // R8: RX queue
    alloc_ok(3, "R8 setup");
    alloc_ok(1, "R8 setup");
    push_rx(7'd0);
    push_rx(7'd1);
    check("R8 head", qstat, 16'h0080);
    issue(3'd3, 5'd0, 7'd0);
    check("R8 drop head", qstat, 16'h0180);
    check("R8 drop no busy", 16'(busy), 16'd0);
    check("R8 drop keeps pages", minfo, exp_minfo());
    issue(3'd4, 5'd0, 7'd0);
    check("R8 free busy", 16'(busy), 16'd1);
    step();
    m_owned[1] = 0; m_free += m_pages[1];
    check("R8 freed", minfo, exp_minfo());
    check("R8 empty", qstat, 16'h8080);

    // R9: TX clear leaves RX
    issue(3'd6, 5'd0, 7'd2);
    issue(3'd6, 5'd0, 7'd4);
    push_rx(7'd5);
    issue(3'd7, 5'd0, 7'd0);
    check("R9 tx cleared rx kept", qstat, 16'h0580);
    check("R9 pages kept", minfo, exp_minfo());

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule